// File: doc/BRIEF.md
# Serial Receive Status Tracker

This block keeps the receive-side status of a serial controller channel that can run asynchronous, byte-synchronous or bit-oriented framed (SDLC) traffic. A bit-level receiver hands it one character at a time: the byte, a single error bit and, when the closing flag of a frame is seen, a closing strobe. The tracker queues each character with its status in a three-entry FIFO. It shows the CPU the entry at the head of the queue together with the head's error and last-of-frame bits, and a character-available flag. It also keeps a sticky end-of-frame flag and a sticky overrun flag.

The error bit on an entry means a framing error in asynchronous mode and a failed CRC comparison in the two synchronous modes. The error flag is a view of the head entry, not a latch. When the CPU pops the head, the flag follows the next character. An Error Reset command clears the head's error bit, the overrun flag and the end-of-frame flag. End-of-frame exists only in SDLC mode. It is cleared when the next frame's first byte arrives or when the mode changes.

Top module: `rx_status_tracker`

## Requirements
- R1: `char_avail` is 1 exactly when the FIFO holds at least one entry, and 0 only when it is empty.
- R2: An active-low `rst_n` (asynchronous assert, synchronous release) or a `chan_rst` pulse (synchronous) empties the FIFO and clears `eof_flag` and `overrun`.
- R3: Entries leave in arrival order. There are 3 entries. `rx_data` shows the head byte, or 0 when the FIFO is empty.
- R4: A push into a full FIFO with no pop in the same cycle is dropped and sets `overrun`. `overrun` stays set until an `err_rst` in a cycle that drops nothing, or until a reset.
- R5: A pop on an empty FIFO has no effect. A push together with a pop on a non-empty FIFO, including a full one, keeps the occupancy and accepts the new byte. A push together with a pop on an empty FIFO stores the byte.
- R6: `err_flag` equals the stored error bit of the head entry and is 0 when the FIFO is empty. The bit is not latched: after a pop, the flag shows the next entry's own bit.
- R7: `err_rst` clears the error bit of the current head entry only. Entries behind it keep their own error bits.
- R8: With `mode_sel` = 2'b10 (SDLC), `eof_strobe` sets `eof_flag` on the next cycle. The flag holds while no clearing event occurs.
- R9: In SDLC mode, `eof_flag` is cleared by `err_rst` or by any `rx_push` (the first byte of the next frame). A simultaneous `eof_strobe` wins over both.
- R10: Mode codes are 2'b00 async, 2'b01 sync, 2'b10 SDLC, with 2'b11 treated as non-SDLC. `eof_flag` is 0 in every mode other than SDLC, and any change of `mode_sel` clears it.
- R11: A byte pushed in SDLC mode in the same cycle as `eof_strobe` is stored as the last byte of its frame. `head_last` shows this mark for the head entry and is 0 when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| chan_rst | input | 1 | Channel reset pulse |
| mode_sel | input | 2 | Operating mode select |
| rx_push | input | 1 | Receiver delivers a character |
| rx_byte | input | DATA_W | Received character |
| rx_err | input | 1 | Framing error (async) or CRC mismatch (sync/SDLC) |
| eof_strobe | input | 1 | Closing flag detected |
| err_rst | input | 1 | Error Reset command |
| cpu_pop | input | 1 | CPU consumes the head character |
| rx_data | output | DATA_W | Head character |
| char_avail | output | 1 | FIFO not empty |
| err_flag | output | 1 | Head entry framing/CRC error |
| head_last | output | 1 | Head entry closes a frame |
| eof_flag | output | 1 | Sticky end-of-frame flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench pushes into a full FIFO with and without a pop in the same cycle. A design that tests fullness before counting the pop drops a byte it should keep and raises a false overrun. It issues Error Reset while a bad character sits behind the head. A design that latched the error, or cleared every entry, would then show the wrong flag after the pop. Closing strobes are made to coincide with pushes, Error Reset and mode changes. This exposes a wrong clearing priority on end-of-frame, and a flag that survives a switch out of SDLC. Pops on an empty FIFO, and both kinds of reset in the middle of traffic, show whether occupancy ever wraps or goes stale.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    RXM_ASYNC = 2'b00,
    RXM_SYNC  = 2'b01,
    RXM_SDLC  = 2'b10,
    RXM_RSVD  = 2'b11
  } rx_mode_e;

  function automatic logic is_framed(input logic [1:0] m);
    return m == RXM_SDLC;
  endfunction

endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          din_err,
  input  logic          din_last,
  input  logic          pop,
  input  logic          err_clr,
  output logic [DW-1:0] dout,
  output logic          dout_err,
  output logic          dout_last,
  output logic          not_empty,
  output logic          drop
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] err_q, err_d;
  logic [DEPTH-1:0] last_q, last_d;
  logic [DEPTH-1:0] wen;
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop, is_empty, is_full;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == FULL_CNT);
  assign do_pop   = pop && !is_empty && !clr;
  assign do_push  = push && !clr && (!is_full || do_pop);
  assign drop     = push && !clr && !do_push;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_pop)  rd_d = bump(rd_q);
      if (do_push) wr_d = bump(wr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_comb begin
    err_d  = err_q;
    last_d = last_q;
    wen    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (err_clr && !is_empty && !clr && (rd_q == PW'(i)))
        err_d[i] = 1'b0;
      if (do_push && (wr_q == PW'(i))) begin
        wen[i]    = 1'b1;
        err_d[i]  = din_err;
        last_d[i] = din_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      err_q  <= '0;
      last_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wen[i]) data_q[i] <= din;
    end
  end

  assign not_empty = !is_empty;
  assign dout      = is_empty ? '0 : data_q[rd_q];
  assign dout_err  = !is_empty && err_q[rd_q];
  assign dout_last = !is_empty && last_q[rd_q];

endmodule

// File: rtl/rxs_frame_flags.sv
module rxs_frame_flags
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] mode_sel,
  input  logic       closing,
  input  logic       push,
  input  logic       err_rst,
  input  logic       drop,
  output logic       eof_flag,
  output logic       overrun
);

  logic [1:0] mode_q, mode_d;
  logic       eof_q, eof_d;
  logic       ovr_q, ovr_d;
  logic       mode_chg, framed;

  assign mode_chg = (mode_sel != mode_q);
  assign framed   = is_framed(mode_sel);
  assign mode_d   = mode_sel;

  always_comb begin
    eof_d = eof_q;
    if (clr || !framed || mode_chg) eof_d = 1'b0;
    else if (closing)               eof_d = 1'b1;
    else if (push || err_rst)       eof_d = 1'b0;
  end

  always_comb begin
    ovr_d = ovr_q;
    if (clr)          ovr_d = 1'b0;
    else if (drop)    ovr_d = 1'b1;
    else if (err_rst) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RXM_ASYNC;
      eof_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      eof_q  <= eof_d;
      ovr_q  <= ovr_d;
    end
  end

  assign eof_flag = eof_q;
  assign overrun  = ovr_q;

endmodule

// File: rtl/rx_status_tracker.sv
module rx_status_tracker
  import rxs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 3,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic [1:0]        mode_sel,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_err,
  input  logic              eof_strobe,
  input  logic              err_rst,
  input  logic              cpu_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              char_avail,
  output logic              err_flag,
  output logic              head_last,
  output logic              eof_flag,
  output logic              overrun
);

  logic rst_sync_n;
  logic fifo_drop;
  logic mark_last;

  rxs_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign mark_last = eof_strobe && is_framed(mode_sel);

  rxs_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (chan_rst),
    .push      (rx_push),
    .din       (rx_byte),
    .din_err   (rx_err),
    .din_last  (mark_last),
    .pop       (cpu_pop),
    .err_clr   (err_rst),
    .dout      (rx_data),
    .dout_err  (err_flag),
    .dout_last (head_last),
    .not_empty (char_avail),
    .drop      (fifo_drop)
  );

  rxs_frame_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (chan_rst),
    .mode_sel (mode_sel),
    .closing  (eof_strobe),
    .push     (rx_push),
    .err_rst  (err_rst),
    .drop     (fifo_drop),
    .eof_flag (eof_flag),
    .overrun  (overrun)
  );

endmodule

// File: rtl/rxs_chk.sv
module rxs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_rst,
  input logic [1:0] mode_sel,
  input logic       rx_push,
  input logic       cpu_pop,
  input logic       err_rst,
  input logic       eof_strobe,
  input logic       char_avail,
  input logic       err_flag,
  input logic       head_last,
  input logic       eof_flag,
  input logic       overrun
);

  // R1
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !chan_rst) |=> char_avail);

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_avail && cpu_pop && !rx_push) |=> !char_avail);

  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_rst && !chan_rst) |=> overrun);

  // R6
  empty_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_avail |-> (!err_flag && !head_last));

  // R8
  eof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_flag && eof_strobe && mode_sel == 2'b10 && !chan_rst) |=> eof_flag);

  // R9
  eof_push_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_flag && rx_push && !eof_strobe) |=> !eof_flag);

  // R10
  eof_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b10) |=> !eof_flag);

endmodule

bind rx_status_tracker rxs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .chan_rst   (chan_rst),
  .mode_sel   (mode_sel),
  .rx_push    (rx_push),
  .cpu_pop    (cpu_pop),
  .err_rst    (err_rst),
  .eof_strobe (eof_strobe),
  .char_avail (char_avail),
  .err_flag   (err_flag),
  .head_last  (head_last),
  .eof_flag   (eof_flag),
  .overrun    (overrun)
);

// File: tb/sim_rx_status_tracker.sv
`timescale 1ns/1ps
module sim_rx_status_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_rst = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       rx_push = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_err = 1'b0;
  logic       eof_strobe = 1'b0;
  logic       err_rst = 1'b0;
  logic       cpu_pop = 1'b0;
  logic [7:0] rx_data;
  logic       char_avail, err_flag, head_last, eof_flag, overrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct packed { logic [7:0] d; logic e; logic l; } ent_t;
  ent_t       mq[$];
  logic       m_eof, m_ovr;
  logic [1:0] m_mode;

  always #10 clk = ~clk;

  rx_status_tracker u0 (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .mode_sel(mode_sel),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_err(rx_err),
    .eof_strobe(eof_strobe), .err_rst(err_rst), .cpu_pop(cpu_pop),
    .rx_data(rx_data), .char_avail(char_avail), .err_flag(err_flag),
    .head_last(head_last), .eof_flag(eof_flag), .overrun(overrun)
  );

  function automatic logic exp_avail();
    return mq.size() > 0;
  endfunction
  function automatic logic [7:0] exp_data();
    return (mq.size() > 0) ? mq[0].d : 8'h00;
  endfunction
  function automatic logic exp_err();
    return (mq.size() > 0) ? mq[0].e : 1'b0;
  endfunction
  function automatic logic exp_last();
    return (mq.size() > 0) ? mq[0].l : 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({"R1 ", tag}, "char_avail", {7'd0, char_avail}, {7'd0, exp_avail()});
    chk({"R3 ", tag}, "rx_data", rx_data, exp_data());
    chk({"R6 R7 ", tag}, "err_flag", {7'd0, err_flag}, {7'd0, exp_err()});
    chk({"R11 ", tag}, "head_last", {7'd0, head_last}, {7'd0, exp_last()});
    chk({"R8 R9 R10 ", tag}, "eof_flag", {7'd0, eof_flag}, {7'd0, m_eof});
    chk({"R4 ", tag}, "overrun", {7'd0, overrun}, {7'd0, m_ovr});
  endtask

  function automatic void model_step(input logic p, input logic [7:0] b, input logic e,
                                     input logic es, input logic er, input logic pp,
                                     input logic [1:0] md, input logic cr);
    logic full, dpop, dpush;
    if (cr) begin
      mq.delete();
      m_eof  = 1'b0;
      m_ovr  = 1'b0;
      m_mode = md;
      return;
    end
    if (er && mq.size() > 0) mq[0].e = 1'b0;
    full  = (mq.size() == 3);
    dpop  = pp && mq.size() > 0;
    dpush = p && (!full || dpop);
    if (dpop) void'(mq.pop_front());
    if (dpush) mq.push_back('{d: b, e: e, l: (es && md == 2'b10)});
    if (p && !dpush) m_ovr = 1'b1;
    else if (er)     m_ovr = 1'b0;
    if (md != 2'b10 || md != m_mode) m_eof = 1'b0;
    else if (es)                     m_eof = 1'b1;
    else if (p || er)                m_eof = 1'b0;
    m_mode = md;
  endfunction

  task automatic step(input string tag, input logic p, input logic [7:0] b, input logic e,
                      input logic es, input logic er, input logic pp,
                      input logic [1:0] md, input logic cr);
    @(negedge clk);
    check_all(tag);
    rx_push = p; rx_byte = b; rx_err = e; eof_strobe = es;
    err_rst = er; cpu_pop = pp; mode_sel = md; chan_rst = cr;
    model_step(p, b, e, es, er, pp, md, cr);
  endtask

  task automatic idle(input int n, input logic [1:0] md);
    for (int i = 0; i < n; i++) step("idle", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, md, 1'b0);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    check_all("pre-reset");
    rst_n = 1'b0;
    rx_push = 1'b0; eof_strobe = 1'b0; err_rst = 1'b0; cpu_pop = 1'b0;
    chan_rst = 1'b0; mode_sel = 2'b00;
    mq.delete(); m_eof = 1'b0; m_ovr = 1'b0; m_mode = 2'b00;
    #1;
    // R2: asynchronous clear is visible at once
    check_all("R2 hw reset asserted");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R2 after release");
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    mq.delete(); m_eof = 1'b0; m_ovr = 1'b0; m_mode = 2'b00;
    repeat (3) @(negedge clk);
    check_all("R2 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 fill, overflow, ordered drain
    step("R3 push a", 1, 8'hA1, 0, 0, 0, 0, 2'b00, 0);
    step("R3 push b", 1, 8'hB2, 1, 0, 0, 0, 2'b00, 0);
    step("R3 push c", 1, 8'hC3, 0, 0, 0, 0, 2'b00, 0);
    step("R4 push full", 1, 8'hD4, 0, 0, 0, 0, 2'b00, 0);
    step("R5 full push+pop", 1, 8'hE5, 1, 0, 0, 1, 2'b00, 0);
    step("R6 pop", 0, 8'h00, 0, 0, 0, 1, 2'b00, 0);
    // R7: clear head error, later entry keeps its own bit
    step("R7 err_rst", 0, 8'h00, 0, 0, 1, 0, 2'b00, 0);
    step("R7 pop", 0, 8'h00, 0, 0, 0, 1, 2'b00, 0);
    step("R6 pop", 0, 8'h00, 0, 0, 0, 1, 2'b00, 0);
    step("R5 empty pop", 0, 8'h00, 0, 0, 0, 1, 2'b00, 0);
    step("R5 empty push+pop", 1, 8'h5A, 1, 0, 0, 1, 2'b00, 0);
    step("R4 err_rst overrun", 0, 8'h00, 0, 0, 1, 0, 2'b00, 0);
    // R8 R9 R10 R11 SDLC frame handling
    step("R10 to sdlc", 0, 8'h00, 0, 0, 0, 1, 2'b10, 0);
    step("R11 closing byte", 1, 8'h7E, 1, 1, 0, 0, 2'b10, 0);
    step("R8 hold", 0, 8'h00, 0, 0, 0, 0, 2'b10, 0);
    step("R9 next frame byte", 1, 8'h11, 0, 0, 0, 0, 2'b10, 0);
    step("R8 strobe", 0, 8'h00, 0, 1, 0, 0, 2'b10, 0);
    step("R9 strobe beats err_rst", 0, 8'h00, 0, 1, 1, 0, 2'b10, 0);
    step("R9 err_rst", 0, 8'h00, 0, 0, 1, 0, 2'b10, 0);
    step("R8 strobe", 0, 8'h00, 0, 1, 0, 0, 2'b10, 0);
    step("R10 mode change", 0, 8'h00, 0, 1, 0, 0, 2'b01, 0);
    step("R10 sync strobe", 1, 8'h22, 0, 1, 0, 0, 2'b01, 0);
    step("R10 rsvd strobe", 0, 8'h00, 0, 1, 0, 0, 2'b11, 0);
    step("R2 chan reset", 1, 8'h33, 0, 0, 0, 0, 2'b10, 1);
    idle(2, 2'b10);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] md;
      logic [2:0] pick;
      md = mode_sel;
      if ($urandom_range(39) == 0) begin
        pick = 3'($urandom_range(5));
        md = (pick < 3) ? 2'b10 : 2'(pick - 3);
      end
      step("random",
           ($urandom_range(1) == 0), 8'($urandom), ($urandom_range(2) == 0),
           ($urandom_range(7) == 0), ($urandom_range(9) == 0),
           ($urandom_range(2) == 0), md, ($urandom_range(149) == 0));
      if (n == 2000) hw_reset();
    end
    idle(1, mode_sel);
    @(negedge clk);
    check_all("final");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule